// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block arbitrates eight interrupt sources for a small processor core. Six sources arrive as ready-made pending lines together with their enable and priority bits. The other two are active-low external pins. Each pin is configured through a bit-addressable control byte. The byte holds, for each pin, a trigger-mode bit, a pending flag, an enable bit and a priority bit. In falling-edge mode a detected edge latches the pending flag, and the flag clears when the core acknowledges that source. In low-level mode the request follows the synchronized pin, and no flag is latched.

The controller picks one winner. High-priority requests beat low-priority ones, and a fixed polling order decides within a level. It presents the winner's index and vector address with a request strobe. The core pulses an acknowledge when service of the presented source begins. It pulses a return when a handler finishes. The block tracks which levels are in service: a low-level handler can be preempted only by a high-priority request, and nothing preempts a high-level handler.

Top module: `irq_prio_ctrl`

## Requirements
- R1: In reset, and in the cycle after reset is released, the control byte reads 00h, no request is raised and no level is in service (`act_lvl` = 00).
- R2: A byte write loads the whole control byte on the next edge. A single-bit write sets or clears only the selected bit. When both are asked in the same cycle, the byte write wins and the single-bit write is dropped.
- R3: Control byte fields for pin 0 / pin 1: trigger mode bit 0 / 4 (1 = falling edge), pending flag bit 1 / 5, enable bit 2 / 6, priority bit 3 / 7 (1 = high). In edge mode the pin must be seen high on one clock and low on the next. The flag then reads 1 one clock after the low sample. A rising edge or a steady level does not set it.
- R4: In level mode a low pin raises a request one clock after it is sampled, and the pending flag is not set.
- R5: Source indices 0..7 are the core lines 0..5 followed by pin 0 and pin 1. Within a level the lowest index wins. The vector is 03h + 8 x index.
- R6: Any enabled pending high-priority source beats every low-priority one.
- R7: A source whose enable is 0 never raises a request.
- R8: Acknowledging an edge-mode pin clears that pin's flag only. The other pin's flag is unchanged.
- R9: If a new falling edge is detected on the same clock that an acknowledge clears that pin's flag, the flag stays set.
- R10: While a low-priority handler is in service only high-priority sources may request. While a high-priority handler is in service no request is raised. `act_lvl` is {high, low} in service.
- R11: A return pulse ends the highest level in service and restores the level that was active before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Write the whole control byte |
| ctl_wdata | input | 8 | Data for byte write |
| ctl_bit_we | input | 1 | Write a single control bit |
| ctl_bit_sel | input | 3 | Bit position for single-bit write |
| ctl_bit_val | input | 1 | Value for single-bit write |
| ctl_rdata | output | 8 | Current control byte |
| xpin_n | input | 2 | Active-low external interrupt pins |
| core_pend | input | 6 | Pending lines of sources 0..5 |
| core_en | input | 6 | Enables of sources 0..5 |
| core_hi | input | 6 | High-priority select of sources 0..5 |
| irq_ack | input | 1 | Core starts servicing the presented source |
| irq_ret | input | 1 | Core returns from the current handler |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 8 | Vector address of the winner |
| irq_src | output | 3 | Index of the winner |
| act_lvl | output | 2 | Levels in service {high, low} |

## Verification
The block has two collision points. The first is a hardware set and a hardware clear of the same pending flag on one clock. The bench re-arms a pin so that its falling edge is being detected on the very clock it acknowledges that pin, then reads the control byte back and expects the flag still set. The second is a byte write and a single-bit write arriving together. The bench issues both and checks that only the byte value lands. Preemption is judged by stacking a high-priority acknowledge on top of a low one and unwinding with returns, while the bench watches the request and vector at each step.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int SRC_N  = 8;
    localparam int XPIN_N = 2;
    localparam int CORE_N = SRC_N - XPIN_N;
    localparam int IDX_W  = $clog2(SRC_N);
    localparam int FLD_W  = 4;
    localparam int CTL_W  = XPIN_N * FLD_W;
    localparam int SEL_W  = $clog2(CTL_W);

    // field offsets inside one pin's nibble
    localparam int FLD_IT = 0;   // trigger: 1 = falling edge
    localparam int FLD_IE = 1;   // pending flag
    localparam int FLD_EX = 2;   // enable
    localparam int FLD_PX = 3;   // priority: 1 = high

    typedef logic [IDX_W-1:0] src_idx_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } act_t;

    typedef struct packed {
        logic     valid;
        logic     hi;
        src_idx_t idx;
    } pick_t;

    function automatic pick_t first_of(input logic [SRC_N-1:0] req, input logic hi);
        pick_t r;
        r = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (req[i]) begin
                r.valid = 1'b1;
                r.hi    = hi;
                r.idx   = src_idx_t'(i);
            end
        end
        return r;
    endfunction

    function automatic logic [7:0] vec_of(input src_idx_t idx, input logic [7:0] base,
                                          input logic [7:0] step);
        return base + 8'(idx) * step;
    endfunction
endpackage

// File: rtl/irq_xpin_ctl.sv
module irq_xpin_ctl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [XPIN_N-1:0] pin_n,
    input  logic              byte_we,
    input  logic [CTL_W-1:0]  byte_d,
    input  logic              bit_we,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic              bit_d,
    input  logic [XPIN_N-1:0] ack_clr,
    output logic [CTL_W-1:0]  ctl_q,
    output logic [XPIN_N-1:0] xreq
);
    logic [XPIN_N-1:0] pin_s, pin_p, fall;
    logic [CTL_W-1:0]  sw_v, ctl_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_s <= '1;
            pin_p <= '1;
        end else begin
            pin_s <= pin_n;
            pin_p <= pin_s;
        end
    end

    assign fall = pin_p & ~pin_s;

    always_comb begin
        sw_v = ctl_q;
        if (byte_we)
            sw_v = byte_d;
        else if (bit_we)
            sw_v[bit_sel] = bit_d;
        ctl_d = sw_v;
        for (int p = 0; p < XPIN_N; p++) begin
            if (ctl_q[p*FLD_W+FLD_IT]) begin
                if (fall[p])
                    ctl_d[p*FLD_W+FLD_IE] = 1'b1;
                else if (ack_clr[p])
                    ctl_d[p*FLD_W+FLD_IE] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    for (genvar p = 0; p < XPIN_N; p++) begin : g_pin
        assign xreq[p] = ctl_q[p*FLD_W+FLD_IT] ? ctl_q[p*FLD_W+FLD_IE] : ~pin_s[p];

        p_edge_sets_flag_r3: assert property (@(posedge clk) disable iff (rst)
            (fall[p] && ctl_q[p*FLD_W+FLD_IT]) |=> ctl_q[p*FLD_W+FLD_IE]);

        // R9: a detected edge outranks an acknowledge clear
        p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
            (ack_clr[p] && ctl_q[p*FLD_W+FLD_IT] && !fall[p] && !byte_we && !bit_we)
            |=> !ctl_q[p*FLD_W+FLD_IE]);

        p_level_no_latch_r4: assert property (@(posedge clk) disable iff (rst)
            (!ctl_q[p*FLD_W+FLD_IT] && !byte_we && !bit_we)
            |=> $stable(ctl_q[p*FLD_W+FLD_IE]));
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic [SRC_N-1:0] pend,
    input  logic [SRC_N-1:0] en,
    input  logic [SRC_N-1:0] hi,
    input  act_t             act,
    output pick_t            sel
);
    logic [SRC_N-1:0] req_h, req_l;
    pick_t            pk_h, pk_l;

    assign req_h = pend & en & hi;
    assign req_l = pend & en & ~hi;
    assign pk_h  = first_of(req_h, 1'b1);
    assign pk_l  = first_of(req_l, 1'b0);

    always_comb begin
        sel = '0;
        if (!act.hi) begin
            if (pk_h.valid)
                sel = pk_h;
            else if (!act.lo)
                sel = pk_l;
        end
    end
endmodule

// File: rtl/irq_level.sv
module irq_level
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic take_hi,
    input  logic ret,
    output act_t act_q
);
    act_t act_d;

    always_comb begin
        act_d = act_q;
        if (ret) begin
            if (act_q.hi) act_d.hi = 1'b0;
            else          act_d.lo = 1'b0;
        end
        if (take) begin
            if (take_hi) act_d.hi = 1'b1;
            else         act_d.lo = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) act_q <= '0;
        else     act_q <= act_d;
    end

    p_ret_restores_r11: assert property (@(posedge clk) disable iff (rst)
        (ret && !take && act_q.hi) |=> (!act_q.hi && act_q.lo == $past(act_q.lo)));

    p_take_hi_r10: assert property (@(posedge clk) disable iff (rst)
        (take && take_hi) |=> act_q.hi);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter logic [7:0] VEC_BASE = 8'h03,
    parameter logic [7:0] VEC_STEP = 8'h08
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              ctl_bit_we,
    input  logic [SEL_W-1:0]  ctl_bit_sel,
    input  logic              ctl_bit_val,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic [XPIN_N-1:0] xpin_n,
    input  logic [CORE_N-1:0] core_pend,
    input  logic [CORE_N-1:0] core_en,
    input  logic [CORE_N-1:0] core_hi,
    input  logic              irq_ack,
    input  logic              irq_ret,
    output logic              irq_req,
    output logic [7:0]        irq_vec,
    output logic [IDX_W-1:0]  irq_src,
    output logic [1:0]        act_lvl
);
    logic [CTL_W-1:0]  ctl_q;
    logic [XPIN_N-1:0] xreq, ack_clr;
    logic [SRC_N-1:0]  pend_all, en_all, hi_all;
    pick_t             sel;
    act_t              act;
    logic              take;

    irq_xpin_ctl u_xpin (
        .clk     (clk),
        .rst     (rst),
        .pin_n   (xpin_n),
        .byte_we (ctl_we),
        .byte_d  (ctl_wdata),
        .bit_we  (ctl_bit_we),
        .bit_sel (ctl_bit_sel),
        .bit_d   (ctl_bit_val),
        .ack_clr (ack_clr),
        .ctl_q   (ctl_q),
        .xreq    (xreq)
    );

    assign pend_all[CORE_N-1:0] = core_pend;
    assign en_all[CORE_N-1:0]   = core_en;
    assign hi_all[CORE_N-1:0]   = core_hi;

    for (genvar p = 0; p < XPIN_N; p++) begin : g_xsrc
        assign pend_all[CORE_N+p] = xreq[p];
        assign en_all[CORE_N+p]   = ctl_q[p*FLD_W+FLD_EX];
        assign hi_all[CORE_N+p]   = ctl_q[p*FLD_W+FLD_PX];
        assign ack_clr[p]         = take && (sel.idx == src_idx_t'(CORE_N + p));
    end

    irq_arbiter u_arb (
        .pend (pend_all),
        .en   (en_all),
        .hi   (hi_all),
        .act  (act),
        .sel  (sel)
    );

    assign take = irq_ack && sel.valid;

    irq_level u_lvl (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .take_hi (sel.hi),
        .ret     (irq_ret),
        .act_q   (act)
    );

    assign irq_req   = sel.valid;
    assign irq_src   = sel.idx;
    assign irq_vec   = vec_of(sel.idx, VEC_BASE, VEC_STEP);
    assign ctl_rdata = ctl_q;
    assign act_lvl   = {act.hi, act.lo};

    // sources of the winner's level sitting below the winner's index
    logic [SRC_N-1:0] below_mask, same_lvl;
    assign below_mask = (SRC_N'(1) << sel.idx) - SRC_N'(1);
    assign same_lvl   = pend_all & en_all & (sel.hi ? hi_all : ~hi_all);

    p_winner_live_r7: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (pend_all[irq_src] && en_all[irq_src]));

    p_poll_order_r5: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> ((same_lvl & below_mask) == '0));

    p_hi_blocks_all_r10: assert property (@(posedge clk) disable iff (rst)
        act.hi |-> !irq_req);

    p_lo_admits_hi_r10: assert property (@(posedge clk) disable iff (rst)
        (act.lo && irq_req) |-> hi_all[irq_src]);
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       ctl_we, ctl_bit_we, ctl_bit_val;
    logic [7:0] ctl_wdata, ctl_rdata;
    logic [2:0] ctl_bit_sel;
    logic [1:0] xpin_n;
    logic [5:0] core_pend, core_en, core_hi;
    logic       irq_ack, irq_ret, irq_req;
    logic [7:0] irq_vec;
    logic [2:0] irq_src;
    logic [1:0] act_lvl;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_bit_we(ctl_bit_we), .ctl_bit_sel(ctl_bit_sel), .ctl_bit_val(ctl_bit_val),
        .ctl_rdata(ctl_rdata), .xpin_n(xpin_n), .core_pend(core_pend),
        .core_en(core_en), .core_hi(core_hi), .irq_ack(irq_ack), .irq_ret(irq_ret),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_src(irq_src), .act_lvl(act_lvl)
    );

    typedef struct packed {
        logic [5:0] pend;
        logic [5:0] en;
        logic [5:0] hi;
        logic       req;
        logic [7:0] vec;
    } tv_t;

    localparam int TV_N = 9;
    localparam tv_t TV [TV_N] = '{
        '{6'b000001, 6'b000001, 6'b000000, 1'b1, 8'h03},  // R5 single source
        '{6'b000010, 6'b111111, 6'b000000, 1'b1, 8'h0B},  // R5
        '{6'b101010, 6'b111111, 6'b000000, 1'b1, 8'h0B},  // R5 lowest index
        '{6'b110000, 6'b111111, 6'b000000, 1'b1, 8'h23},  // R5
        '{6'b100001, 6'b111111, 6'b100000, 1'b1, 8'h2B},  // R6 high beats low
        '{6'b111111, 6'b111110, 6'b000000, 1'b1, 8'h0B},  // R7 masked index 0
        '{6'b010100, 6'b000000, 6'b000000, 1'b0, 8'h00},  // R7 nothing enabled
        '{6'b010100, 6'b010100, 6'b010100, 1'b1, 8'h13},  // R5 within high level
        '{6'b001000, 6'b001000, 6'b000000, 1'b1, 8'h1B}   // R5
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic bit_wr(input logic [2:0] sel, input logic v);
        ctl_bit_we = 1'b1; ctl_bit_sel = sel; ctl_bit_val = v;
        step();
        ctl_bit_we = 1'b0;
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
    endtask

    task automatic pulse_ret();
        irq_ret = 1'b1; step(); irq_ret = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; ctl_we = 0; ctl_wdata = 0; ctl_bit_we = 0; ctl_bit_sel = 0;
        ctl_bit_val = 0; xpin_n = 2'b11; core_pend = 0; core_en = 0; core_hi = 0;
        irq_ack = 0; irq_ret = 0;
        repeat (3) step();
        chk("R1 ctl in reset", ctl_rdata, 8'h00);
        chk("R1 req in reset", irq_req, 1'b0);
        rst = 1'b0;
        step();
        chk("R1 ctl after reset", ctl_rdata, 8'h00);
        chk("R1 level after reset", act_lvl, 2'b00);

        // table of arbitration vectors, pins disabled
        for (int i = 0; i < TV_N; i++) begin
            core_pend = TV[i].pend; core_en = TV[i].en; core_hi = TV[i].hi;
            step();
            chk($sformatf("R5/R6/R7 vec %0d req", i), irq_req, TV[i].req);
            if (TV[i].req) chk($sformatf("R5 vec %0d addr", i), irq_vec, TV[i].vec);
        end
        core_pend = 0; core_en = 0; core_hi = 0;

        // R2 byte and bit writes
        ctl_we = 1'b1; ctl_wdata = 8'h05; step(); ctl_we = 1'b0;
        chk("R2 byte write", ctl_rdata, 8'h05);
        bit_wr(3'd4, 1'b1);
        bit_wr(3'd6, 1'b1);
        chk("R2 bit sets", ctl_rdata, 8'h55);
        bit_wr(3'd2, 1'b0);
        chk("R2 bit clear", ctl_rdata, 8'h51);
        bit_wr(3'd2, 1'b1);
        ctl_we = 1'b1; ctl_wdata = 8'h55; ctl_bit_we = 1'b1; ctl_bit_sel = 3'd7; ctl_bit_val = 1'b1;
        step();
        ctl_we = 1'b0; ctl_bit_we = 1'b0;
        chk("R2 byte wins over bit", ctl_rdata, 8'h55);
        chk("R3 no request without edge", irq_req, 1'b0);

        // R3 edge latch timing
        xpin_n[0] = 1'b0;
        step();
        chk("R3 flag not yet latched", ctl_rdata[1], 1'b0);
        step();
        chk("R3 flag latched", ctl_rdata[1], 1'b1);
        chk("R3 request", irq_req, 1'b1);
        chk("R5 pin0 vector", irq_vec, 8'h33);
        chk("R5 pin0 index", irq_src, 3'd6);

        // R8 both flags, ack clears only the winner's
        xpin_n[1] = 1'b0;
        step(); step();
        chk("R3 pin1 flag", ctl_rdata, 8'h77);
        pulse_ack();
        chk("R8 only pin0 flag cleared", ctl_rdata, 8'h75);
        chk("R10 low in service", act_lvl, 2'b01);
        chk("R10 low blocks low", irq_req, 1'b0);
        pulse_ret();
        chk("R11 back to idle", act_lvl, 2'b00);
        chk("R5 pin1 vector", irq_vec, 8'h3B);
        pulse_ack();
        chk("R8 pin1 flag cleared", ctl_rdata, 8'h55);
        pulse_ret();
        xpin_n = 2'b11;
        step(); step();
        chk("R3 rising edge sets nothing", ctl_rdata, 8'h55);

        // R9 set and clear collide
        xpin_n[0] = 1'b0; step(); step();
        xpin_n[0] = 1'b1; step();
        xpin_n[0] = 1'b0; step();
        chk("R9 flag set before collision", irq_req, 1'b1);
        pulse_ack();
        chk("R9 edge wins over clear", ctl_rdata[1], 1'b1);
        pulse_ret();
        pulse_ack();
        chk("R8 flag cleared later", ctl_rdata[1], 1'b0);
        pulse_ret();
        xpin_n[0] = 1'b1; step();

        // R4 level mode on pin 1
        bit_wr(3'd4, 1'b0);
        chk("R4 mode cleared", ctl_rdata, 8'h45);
        xpin_n[1] = 1'b0;
        step();
        chk("R4 level request", irq_req, 1'b1);
        chk("R4 level vector", irq_vec, 8'h3B);
        chk("R4 no flag", ctl_rdata[5], 1'b0);
        pulse_ack();
        pulse_ret();
        xpin_n[1] = 1'b1;
        step();
        chk("R4 request follows pin", irq_req, 1'b0);

        // R10 / R11 nesting with core sources
        core_en = 6'b111111;
        core_pend[1] = 1'b1;
        step();
        chk("R5 timer source", irq_vec, 8'h0B);
        pulse_ack();
        chk("R10 low taken", act_lvl, 2'b01);
        chk("R10 low pending blocked", irq_req, 1'b0);
        core_pend[4] = 1'b1; core_hi[4] = 1'b1;
        step();
        chk("R10 high preempts", irq_req, 1'b1);
        chk("R10 high vector", irq_vec, 8'h23);
        pulse_ack();
        chk("R10 nested level", act_lvl, 2'b11);
        core_pend[0] = 1'b1; core_hi[0] = 1'b1;
        step();
        chk("R10 high blocks all", irq_req, 1'b0);
        pulse_ret();
        chk("R11 restores low", act_lvl, 2'b01);
        chk("R11 high again allowed", irq_vec, 8'h03);
        pulse_ret();
        chk("R11 restores idle", act_lvl, 2'b00);
        chk("R6 idle winner", irq_vec, 8'h03);

        finish_run();
    end
endmodule